// File: doc/BRIEF.md
# Banked Memory and I/O Decoder

This block sits between the 8-bit address bus of a small 8-bit CPU and its memories and peripherals. Each CPU address is sorted into one of five fixed regions: a 16-byte boot ROM page, a common RAM page that holds the stack and its pointers, a block of sixteen I/O ports, a banked window, and a small free RAM page. The block then drives the chip selects and the physical address for that region.

A bank register sits behind one of the I/O ports. Software writes it to choose what the window at CPU addresses 0x80 to 0xEF reaches. The register value becomes the upper byte of the physical address. If its top bit is clear, the window reaches banked RAM. If its top bit is set, the window reaches ROM. The boot page always maps to physical 0x8080 to 0x808F, whatever the bank value, so with bank 0x80 the ROM code that follows the boot bytes starts at physical 0x8090. The block also puts the bank value on the read data lines during a read of the bank port, and it drives zero there for every other read it decodes.

Top module: `bank_dec_top`

## Requirements
- R1: After reset the bank register holds 0x00. A read (rd_i high) of CPU address 0x74 drives the current bank value on rdata_o.
- R2: CPU addresses 0x00 to 0x0F assert rom_cs_o during a strobe and give phys_addr_o = 0x8080 + addr[3:0], for every bank value.
- R3: CPU addresses 0x10 to 0x6F and 0xF0 to 0xFF assert ram_cs_o during a strobe and give phys_addr_o = 0x00 followed by the CPU address byte, for every bank value.
- R4: CPU addresses 0x70 to 0x7F assert io_cs_o and never rom_cs_o or ram_cs_o. io_sel_o bit addr[3:0] is set only when that port is in use (default ports 0 to 6, that is 0x70 to 0x76). No io_sel_o bit and no io_cs_o is ever set while addr[7] is 1.
- R5: CPU addresses 0x80 to 0xEF give phys_addr_o = {bank, addr}. They assert rom_cs_o when bank bit 7 is 1 and ram_cs_o when it is 0.
- R6: A write (wr_i high) to 0x74 loads wdata_i into the bank register at the next rising clock edge. The bank register does not change in any other cycle.
- R7: An unused port (default 0x77 to 0x7F) raises no io_sel_o bit. A read of it returns 0x00 on rdata_o, and a write to it leaves the bank register unchanged.
- R8: With neither rd_i nor wr_i high, no chip select and no port select is active. During a strobe, exactly one of rom_cs_o, ram_cs_o and io_cs_o is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | CPU address |
| wdata_i | input | 8 | CPU write data |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| phys_addr_o | output | 16 | Physical memory address |
| rom_cs_o | output | 1 | ROM chip select |
| ram_cs_o | output | 1 | RAM chip select |
| io_cs_o | output | 1 | Access falls in the I/O port block |
| io_sel_o | output | 16 | One-hot select of a used I/O port |
| rdata_o | output | 8 | Read data driven by the block (bank readback, zero otherwise) |

## Verification
The assertions are checked on every cycle. They check that the three chip selects are mutually exclusive during a strobe and all quiet outside one. They check that a port select is one-hot and never appears with A7 set. They check that the boot page maps to ROM. They also check that the bank register changes only on a write to its port, and then to the written byte. The exact physical address for each region and bank value, the ROM/RAM split of the window by the bank's top bit, and the readback and zero data of the ports can only be shown by the bench. It sweeps all 256 CPU addresses under several bank values and compares each result with a value computed from the address.

// File: rtl/bank_dec_pkg.sv
package bank_dec_pkg;
  typedef enum logic [2:0] {
    RGN_BOOT,
    RGN_COMMON,
    RGN_IO,
    RGN_WINDOW,
    RGN_FREE
  } region_e;

  localparam logic [7:0] COMMON_BASE = 8'h10;
  localparam logic [7:0] IO_BASE     = 8'h70;
  localparam logic [3:0] BOOT_NIB    = 4'h0;
  localparam logic [3:0] IO_NIB      = 4'h7;
  localparam logic [3:0] FREE_NIB    = 4'hF;
  localparam logic [3:0] BOOT_OFS    = 4'h8;
endpackage

// File: rtl/bank_dec_region.sv
module bank_dec_region
  import bank_dec_pkg::*;
(
  input  logic [7:0] addr_i,
  output region_e    region_o
);
  always_comb begin
    if (addr_i[7:4] == BOOT_NIB)     region_o = RGN_BOOT;
    else if (addr_i < IO_BASE)       region_o = RGN_COMMON;
    else if (addr_i[7:4] == IO_NIB)  region_o = RGN_IO;
    else if (addr_i[7:4] == FREE_NIB) region_o = RGN_FREE;
    else                             region_o = RGN_WINDOW;
  end
endmodule

// File: rtl/bank_dec_reg.sv
module bank_dec_reg #(
  parameter int unsigned BANK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BANK_W-1:0] d_i,
  output logic [BANK_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/bank_dec_io.sv
module bank_dec_io #(
  parameter int unsigned          NUM_PORTS = 16,
  parameter logic [NUM_PORTS-1:0] USED_MASK = 16'h007F,
  parameter int unsigned          BANK_PORT = 4,
  parameter int unsigned          BANK_W    = 8,
  localparam int unsigned         PORT_W    = $clog2(NUM_PORTS)
) (
  input  logic                 io_hit_i,
  input  logic                 rd_i,
  input  logic                 wr_i,
  input  logic [PORT_W-1:0]    port_i,
  input  logic [BANK_W-1:0]    bank_i,
  output logic [NUM_PORTS-1:0] sel_o,
  output logic                 bank_we_o,
  output logic [BANK_W-1:0]    rdata_o
);
  localparam logic [PORT_W-1:0] BANK_IDX = PORT_W'(BANK_PORT);

  logic strobe;
  logic bank_hit;

  assign strobe   = io_hit_i & (rd_i | wr_i);
  assign bank_hit = io_hit_i & (port_i == BANK_IDX) & USED_MASK[BANK_PORT];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    if (USED_MASK[p]) begin : g_used
      assign sel_o[p] = strobe & (port_i == PORT_W'(p));
    end else begin : g_unused
      assign sel_o[p] = 1'b0;
    end
  end

  assign bank_we_o = bank_hit & wr_i;
  // unused ports and external peripherals read as zero from this block
  assign rdata_o   = (bank_hit & rd_i) ? bank_i : '0;
endmodule

// File: rtl/bank_dec_top.sv
module bank_dec_top
  import bank_dec_pkg::*;
#(
  parameter int unsigned   BANK_W    = 8,
  parameter int unsigned   NUM_PORTS = 16,
  parameter logic [15:0]   USED_MASK = 16'h007F,
  parameter int unsigned   BANK_PORT = 4,
  parameter logic [7:0]    BOOT_BANK = 8'h80,
  localparam int unsigned  PHYS_W    = BANK_W + 8,
  localparam int unsigned  PORT_W    = $clog2(NUM_PORTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [7:0]           addr_i,
  input  logic [7:0]           wdata_i,
  input  logic                 rd_i,
  input  logic                 wr_i,
  output logic [PHYS_W-1:0]    phys_addr_o,
  output logic                 rom_cs_o,
  output logic                 ram_cs_o,
  output logic                 io_cs_o,
  output logic [NUM_PORTS-1:0] io_sel_o,
  output logic [7:0]           rdata_o
);
  region_e           region;
  logic [BANK_W-1:0] bank_q;
  logic [BANK_W-1:0] io_rdata;
  logic              bank_we;
  logic              strobe;
  logic              win_rom;

  bank_dec_region u_region (
    .addr_i   (addr_i),
    .region_o (region)
  );

  bank_dec_reg #(.BANK_W(BANK_W)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (bank_we),
    .d_i    (wdata_i[BANK_W-1:0]),
    .q_o    (bank_q)
  );

  bank_dec_io #(
    .NUM_PORTS (NUM_PORTS),
    .USED_MASK (USED_MASK[NUM_PORTS-1:0]),
    .BANK_PORT (BANK_PORT),
    .BANK_W    (BANK_W)
  ) u_io (
    .io_hit_i  (region == RGN_IO),
    .rd_i      (rd_i),
    .wr_i      (wr_i),
    .port_i    (addr_i[PORT_W-1:0]),
    .bank_i    (bank_q),
    .sel_o     (io_sel_o),
    .bank_we_o (bank_we),
    .rdata_o   (io_rdata)
  );

  assign strobe  = rd_i | wr_i;
  assign win_rom = bank_q[BANK_W-1];

  always_comb begin
    unique case (region)
      RGN_BOOT:   phys_addr_o = {BOOT_BANK[BANK_W-1:0], BOOT_OFS, addr_i[3:0]};
      RGN_WINDOW: phys_addr_o = {bank_q, addr_i};
      default:    phys_addr_o = {{BANK_W{1'b0}}, addr_i};
    endcase
  end

  assign rom_cs_o = strobe & ((region == RGN_BOOT) | ((region == RGN_WINDOW) & win_rom));
  assign ram_cs_o = strobe & ((region == RGN_COMMON) | (region == RGN_FREE) |
                              ((region == RGN_WINDOW) & ~win_rom));
  assign io_cs_o  = strobe & (region == RGN_IO);
  assign rdata_o  = 8'(io_rdata);
endmodule

// File: rtl/bank_dec_chk.sv
module bank_dec_chk #(
  parameter int unsigned BANK_W    = 8,
  parameter int unsigned NUM_PORTS = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [7:0]           addr_i,
  input logic [7:0]           wdata_i,
  input logic                 rd_i,
  input logic                 wr_i,
  input logic [BANK_W+7:0]    phys_addr_o,
  input logic                 rom_cs_o,
  input logic                 ram_cs_o,
  input logic                 io_cs_o,
  input logic [NUM_PORTS-1:0] io_sel_o,
  input logic [BANK_W-1:0]    bank_q
);
  AST_ONE_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i | wr_i) |-> $countones({rom_cs_o, ram_cs_o, io_cs_o}) == 1); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i | wr_i) |-> !(rom_cs_o | ram_cs_o | io_cs_o) && io_sel_o == '0); // R8
  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(io_sel_o) && (io_sel_o != '0 -> io_cs_o)); // R4
  AST_HIGH_NO_IO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i[7] |-> !io_cs_o && io_sel_o == '0); // R4
  AST_BOOT_ROM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i[7:4] == 4'h0) |-> rom_cs_o && phys_addr_o[7:4] == 4'h8); // R2
  AST_BANK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 8'h74) |=> bank_q == $past(wdata_i[BANK_W-1:0])); // R6
  AST_BANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == 8'h74) |=> $stable(bank_q)); // R6
endmodule

bind bank_dec_top bank_dec_chk #(.BANK_W(BANK_W), .NUM_PORTS(NUM_PORTS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rd_i        (rd_i),
  .wr_i        (wr_i),
  .phys_addr_o (phys_addr_o),
  .rom_cs_o    (rom_cs_o),
  .ram_cs_o    (ram_cs_o),
  .io_cs_o     (io_cs_o),
  .io_sel_o    (io_sel_o),
  .bank_q      (bank_q)
);

// File: tb/bank_dec_top_test.sv
module bank_dec_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        rd_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [15:0] phys_addr_o;
  logic        rom_cs_o, ram_cs_o, io_cs_o;
  logic [15:0] io_sel_o;
  logic [7:0]  rdata_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bank_dec_top uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .rd_i(rd_i), .wr_i(wr_i), .phys_addr_o(phys_addr_o), .rom_cs_o(rom_cs_o),
    .ram_cs_o(ram_cs_o), .io_cs_o(io_cs_o), .io_sel_o(io_sel_o), .rdata_o(rdata_o)
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic read_bank(input logic [7:0] exp, input string req);
    @(negedge clk_i);
    addr_i = 8'h74; rd_i = 1'b1;
    #1 chk(rdata_o == exp, req, rdata_o, exp);
    rd_i = 1'b0;
  endtask

  // full sweep of CPU addresses with a read strobe under the given bank value
  task automatic sweep(input logic [7:0] bank);
    for (int a = 0; a < 256; a++) begin
      logic [7:0]  ad;
      logic [15:0] e_phys, e_sel;
      logic        e_rom, e_ram, e_io;
      logic [7:0]  e_rd;
      string       req;
      ad = a[7:0];
      e_rom = 0; e_ram = 0; e_io = 0; e_sel = '0; e_rd = '0;
      e_phys = {8'h00, ad};
      if (a < 16) begin
        req = "R2"; e_rom = 1; e_phys = 16'h8080 + 16'(a);
      end else if (a < 16'h70 || a >= 16'hF0) begin
        req = "R3"; e_ram = 1;
      end else if (a < 16'h80) begin
        req = "R4"; e_io = 1;
        if ((a & 15) <= 6) e_sel = 16'(1) << (a & 15);
        else req = "R7";
        if (a == 16'h74) e_rd = bank;
      end else begin
        req = "R5"; e_phys = {bank, ad};
        e_rom = bank[7]; e_ram = ~bank[7];
      end
      @(negedge clk_i);
      addr_i = ad; rd_i = 1'b1;
      #1;
      chk(phys_addr_o == e_phys, req, phys_addr_o, e_phys);
      chk({rom_cs_o, ram_cs_o, io_cs_o} == {e_rom, e_ram, e_io}, req,
          {rom_cs_o, ram_cs_o, io_cs_o}, {e_rom, e_ram, e_io});
      chk(io_sel_o == e_sel, req, io_sel_o, e_sel);
      chk(rdata_o == e_rd, req, rdata_o, e_rd);
      rd_i = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; errors++;
    $display("FAIL watchdog act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] banks [5];
    banks = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hC3};
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: reset value
    read_bank(8'h00, "R1");
    sweep(8'h00);
    for (int i = 1; i < 5; i++) begin
      bus_write(8'h74, banks[i]);             // R6 load
      read_bank(banks[i], "R6");
      sweep(banks[i]);
    end
    // R6: writes elsewhere do not touch the bank
    bus_write(8'h20, 8'h11);
    bus_write(8'h90, 8'h22);
    bus_write(8'h75, 8'h33);
    read_bank(8'hC3, "R6");
    // R7: unused ports ignore writes
    for (int p = 8'h77; p <= 8'h7F; p++) bus_write(p[7:0], 8'h5A);
    read_bank(8'hC3, "R7");
    // R8: no strobe -> nothing selected, all addresses
    for (int a = 0; a < 256; a++) begin
      @(negedge clk_i);
      addr_i = a[7:0]; rd_i = 1'b0; wr_i = 1'b0;
      #1 chk(!(rom_cs_o | ram_cs_o | io_cs_o) && io_sel_o == '0, "R8",
             {rom_cs_o, ram_cs_o, io_cs_o, io_sel_o}, 0);
    end
    // R8: write strobe also gives exactly one select (window, bank C3 -> ROM)
    @(negedge clk_i);
    addr_i = 8'hA0; wdata_i = 8'h00; wr_i = 1'b1;
    #1 chk({rom_cs_o, ram_cs_o, io_cs_o} == 3'b100, "R8", {rom_cs_o, ram_cs_o, io_cs_o}, 3'b100);
    wr_i = 1'b0;
    // R1: reset returns bank to zero
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    read_bank(8'h00, "R1");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule